// File: doc/BRIEF.md
# Multi-mode host bus front end

This block sits between a host processor and the register file of a display controller. Three strap inputs choose how the host talks to it. The choices are a parallel bus in 68-style timing (an enable with a direction line) or in 80-style timing (separate write and read strobes), each 16 or 8 bits wide, or a clock-synchronous serial link. Whatever the mode, the block turns host transfers into single-cycle index-write or control-write pulses that carry a 16-bit word. It returns read data on the parallel output bus, which is enabled only during a read, or on the serial output pin.

The host-side control lines are asynchronous to the system clock. Chip select, the strobe/clock line and the direction/read line each pass through a two-flop synchronizer. Edges are then found on the synchronized copies. A 68-style write takes effect on the falling edge of the enable. An 80-style write takes effect on the rising edge of the write strobe. In the 8-bit modes a byte toggle pairs the upper byte, which is sent first, with the lower byte. The toggle clears whenever chip select is high. A small register stub stands in for the real register bank. It holds an index, which is read back as the status word, and a set of control words selected by that index.

The serial link is run by a state machine with five states. IDLE waits for chip select low and then moves to HEAD. HEAD collects the 8-bit start byte. From HEAD the machine goes to WRITE, to READ, or to HOLD when the start byte is rejected. WRITE collects a 16-bit word, commits it and moves to HOLD. READ shifts the read word out. HOLD ignores the link. Chip select going high returns every state to IDLE. Leaving serial mode also returns every state to IDLE.

Top module: `hostif_front`

## Requirements
- R1: The straps `mode_strap[2:0]` select the mode: 000 is 68-style 16-bit, 001 is 68-style 8-bit, 010 is 80-style 16-bit, 011 is 80-style 8-bit, and 1xx is serial. In serial mode `mode_strap[0]` is the device ID bit that the start byte must match.
- R2: While `cs_n` is high, no strobe produces a write pulse, the register contents are left unchanged, and `db_oe` stays low.
- R3: With `rs` low, a write sets the index and a read returns the status word (the current index, zero-extended). With `rs` high, a write sets the control word at the current index and a read returns that word.
- R4: In 68-style mode, a write with `dir_rd` low commits on the falling edge of `strobe`. A read with `dir_rd` high drives the bus while `strobe` is high.
- R5: In 80-style mode, a write commits on the rising edge of `strobe` (the write strobe, active low). A read drives the bus while `dir_rd` (the read strobe, active low) is low.
- R6: In 8-bit modes, only `db_in[15:8]` carries data, upper byte first and lower byte second, and `db_in[7:0]` is ignored. Reads return the upper byte and then the lower byte on `db_out[15:8]`, with `db_out[7:0]` held at zero.
- R7: A byte left pending when `cs_n` goes high is discarded. The next transfer starts again with the upper byte.
- R8: A serial transfer starts with 8 bits sent MSB first, with `sdi` sampled on rising edges of `strobe`. Bits [7:3] of this start byte must be 01110, bit 2 is the ID, bit 1 is the register select and bit 0 is the direction (1 means read). For a write, 16 data bits follow MSB first, and the word commits after the 16th bit.
- R9: A start byte with a wrong pattern or a non-matching ID causes the rest of the transfer to be ignored.
- R10: In a serial read, `sdo` presents data bit 15 after the first falling edge of `strobe` that follows the start byte, and the next lower bit after each further falling edge. `sdo` is 0 in the parallel modes.
- R11: `db_oe` is high only during an active parallel read with `cs_n` low. It is never high in serial mode.
- R12: Each completed transfer produces exactly one single-cycle pulse on `idx_wr` or on `ctl_wr`, never on both.
- R13: After reset, `db_oe`, `sdo`, `idx_wr` and `ctl_wr` are low, and the index and control words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_strap | input | 3 | Interface mode straps; bit 0 is the device ID in serial mode |
| cs_n | input | 1 | Chip select, active low |
| rs | input | 1 | Register select for the parallel modes (0 index/status, 1 control) |
| strobe | input | 1 | Enable (68-style), write strobe (80-style) or serial clock |
| dir_rd | input | 1 | Direction (68-style, 1 means read) or read strobe (80-style) |
| db_in | input | 16 | Parallel data from the host |
| sdi | input | 1 | Serial data in |
| db_out | output | 16 | Parallel read data |
| db_oe | output | 1 | Output enable for db_out |
| sdo | output | 1 | Serial data out |
| idx_wr | output | 1 | Index write pulse |
| ctl_wr | output | 1 | Control write pulse |
| wdata | output | 16 | Word carried with a write pulse |

## Verification
Every parallel mode gets the same script: an index write, a control write, a control read and a status read. Because the script is the same, a wrong strap decode, a wrong commit edge or swapped bytes each show up as a mismatch in one specific mode. The 8-bit writes put a non-zero pattern on the low data lines, so that any use of those lines changes the committed word. A single byte with chip select then raised, followed by a full two-byte write, separates a toggle that is reset from one that is left stale. On the serial side, good writes and reads are set against start bytes that carry the wrong ID and a wrong sync pattern. Together these show that rejection is decided by the start byte alone, and the two ID strap settings show that the ID bit is read from the strap.

// File: rtl/hif_pkg.sv
package hif_pkg;
    localparam int DW = 16;
    localparam int BW = 8;
    localparam logic [4:0] SER_SYNC = 5'b01110;

    typedef enum logic [1:0] {BUS_M68, BUS_I80, BUS_SER} bus_kind_t;

    typedef struct packed {
        bus_kind_t kind;
        logic      narrow;
        logic      dev_id;
    } hmode_t;

    typedef enum logic [2:0] {SS_IDLE, SS_HEAD, SS_WRITE, SS_READ, SS_HOLD} ser_state_t;

    function automatic hmode_t decode_strap(input logic [2:0] s);
        hmode_t m;
        m.dev_id = s[0];
        if (s[2]) begin
            m.kind   = BUS_SER;
            m.narrow = 1'b0;
        end else begin
            m.kind   = s[1] ? BUS_I80 : BUS_M68;
            m.narrow = s[0];
        end
        return m;
    endfunction
endpackage

// File: rtl/hif_sync.sv
module hif_sync #(
    parameter int           W    = 1,
    parameter logic [W-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= INIT;
            q    <= INIT;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hif_regs.sv
module hif_regs
    import hif_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_wr,
    input  logic          ctl_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_idx,
    output logic [DW-1:0] rd_ctl
);
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

    logic [IW-1:0] idx;
    logic [DW-1:0] word_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
            for (int i = 0; i < NREG; i++) word_q[i] <= '0;
        end else begin
            if (idx_wr) idx <= wdata[IW-1:0];
            if (ctl_wr) word_q[idx] <= wdata;
        end
    end

    assign rd_idx = {{(DW-IW){1'b0}}, idx};
    assign rd_ctl = word_q[idx];
endmodule

// File: rtl/hif_par.sv
module hif_par
    import hif_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          is80,
    input  logic          narrow,
    input  logic          cs_n_s,
    input  logic          stb_s,
    input  logic          dir_s,
    input  logic          rs,
    input  logic [DW-1:0] db_in,
    input  logic [DW-1:0] rd_idx,
    input  logic [DW-1:0] rd_ctl,
    output logic          wr_pulse,
    output logic          wr_rs,
    output logic [DW-1:0] wr_word,
    output logic          oe,
    output logic [DW-1:0] dout
);
    logic          stb_d, dir_d, half;
    logic [BW-1:0] upper;
    logic          stb_rise, stb_fall, dir_rise, commit, rd_end;
    logic [DW-1:0] rword;

    assign stb_rise = stb_s & ~stb_d;
    assign stb_fall = ~stb_s & stb_d;
    assign dir_rise = dir_s & ~dir_d;
    assign commit   = en & ~cs_n_s & (is80 ? stb_rise : (stb_fall & ~dir_s));
    assign rd_end   = en & ~cs_n_s & (is80 ? dir_rise : (stb_fall & dir_s));
    assign oe       = en & ~cs_n_s & (is80 ? ~dir_s : (stb_s & dir_s));
    assign rword    = rs ? rd_ctl : rd_idx;
    assign dout     = narrow ? {(half ? rword[BW-1:0] : rword[DW-1:BW]), {BW{1'b0}}} : rword;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_d    <= 1'b1;
            dir_d    <= 1'b1;
            half     <= 1'b0;
            upper    <= '0;
            wr_pulse <= 1'b0;
            wr_rs    <= 1'b0;
            wr_word  <= '0;
        end else begin
            stb_d    <= stb_s;
            dir_d    <= dir_s;
            wr_pulse <= 1'b0;
            if (commit) begin
                if (!narrow) begin
                    wr_pulse <= 1'b1;
                    wr_rs    <= rs;
                    wr_word  <= db_in;
                end else if (!half) begin
                    upper <= db_in[DW-1:BW];
                    half  <= 1'b1;
                end else begin
                    wr_pulse <= 1'b1;
                    wr_rs    <= rs;
                    wr_word  <= {upper, db_in[DW-1:BW]};
                    half     <= 1'b0;
                end
            end else if (rd_end && narrow) begin
                half <= ~half;
            end
            if (cs_n_s) half <= 1'b0;
        end
    end
endmodule

// File: rtl/hif_ser.sv
module hif_ser
    import hif_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          dev_id,
    input  logic          cs_n_s,
    input  logic          scl_s,
    input  logic          sdi,
    input  logic [DW-1:0] rd_idx,
    input  logic [DW-1:0] rd_ctl,
    output logic          wr_pulse,
    output logic          wr_rs,
    output logic [DW-1:0] wr_word,
    output logic          sdo
);
    localparam int CW = $clog2(DW);

    ser_state_t    state, nxt;
    logic          scl_d, sdo_r;
    logic [CW-1:0] cnt;
    logic [DW-2:0] sh;
    logic [DW-1:0] out_sh;
    logic [BW-1:0] hdr;
    logic          rise, fall, hdr_ok, hdr_last, data_last;

    assign rise      = scl_s & ~scl_d;
    assign fall      = ~scl_s & scl_d;
    assign hdr       = {sh[BW-2:0], sdi};
    assign hdr_ok    = (hdr[7:3] == SER_SYNC) && (hdr[2] == dev_id);
    assign hdr_last  = rise && (cnt == CW'(BW-1));
    assign data_last = rise && (cnt == CW'(DW-1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!en || cs_n_s) begin
            nxt = SS_IDLE;
        end else begin
            unique case (state)
                SS_IDLE:  nxt = SS_HEAD;
                SS_HEAD:  if (hdr_last) nxt = !hdr_ok ? SS_HOLD : (hdr[0] ? SS_READ : SS_WRITE);
                SS_WRITE: if (data_last) nxt = SS_HOLD;
                SS_READ:  nxt = SS_READ;
                SS_HOLD:  nxt = SS_HOLD;
                default:  nxt = SS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d    <= 1'b1;
            sdo_r    <= 1'b0;
            cnt      <= '0;
            sh       <= '0;
            out_sh   <= '0;
            wr_pulse <= 1'b0;
            wr_rs    <= 1'b0;
            wr_word  <= '0;
        end else begin
            scl_d    <= scl_s;
            wr_pulse <= 1'b0;
            unique case (state)
                SS_IDLE: begin
                    cnt   <= '0;
                    sdo_r <= 1'b0;
                end
                SS_HEAD: if (rise) begin
                    sh <= {sh[DW-3:0], sdi};
                    if (hdr_last) begin
                        cnt    <= '0;
                        wr_rs  <= hdr[1];
                        out_sh <= hdr[1] ? rd_ctl : rd_idx;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SS_WRITE: if (rise) begin
                    sh  <= {sh[DW-3:0], sdi};
                    cnt <= cnt + 1'b1;
                    if (data_last) begin
                        wr_pulse <= 1'b1;
                        wr_word  <= {sh, sdi};
                    end
                end
                SS_READ: if (fall) begin
                    sdo_r  <= out_sh[DW-1];
                    out_sh <= {out_sh[DW-2:0], 1'b0};
                end
                SS_HOLD: ;
                default: ;
            endcase
        end
    end

    assign sdo = (state == SS_READ) ? sdo_r : 1'b0;
endmodule

// File: rtl/hostif_front.sv
module hostif_front
    import hif_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mode_strap,
    input  logic          cs_n,
    input  logic          rs,
    input  logic          strobe,
    input  logic          dir_rd,
    input  logic [DW-1:0] db_in,
    input  logic          sdi,
    output logic [DW-1:0] db_out,
    output logic          db_oe,
    output logic          sdo,
    output logic          idx_wr,
    output logic          ctl_wr,
    output logic [DW-1:0] wdata
);
    hmode_t        md;
    logic [2:0]    ctl_s;
    logic          ser_en;
    logic          p_pulse, p_rs, s_pulse, s_rs, pulse, rs_sel;
    logic [DW-1:0] p_word, s_word, rd_idx, rd_ctl;

    assign md     = decode_strap(mode_strap);
    assign ser_en = (md.kind == BUS_SER);

    hif_sync #(.W(3), .INIT(3'b111)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, strobe, dir_rd}), .q(ctl_s)
    );

    hif_par u_par (
        .clk(clk), .rst_n(rst_n), .en(~ser_en), .is80(md.kind == BUS_I80),
        .narrow(md.narrow), .cs_n_s(ctl_s[2]), .stb_s(ctl_s[1]), .dir_s(ctl_s[0]),
        .rs(rs), .db_in(db_in), .rd_idx(rd_idx), .rd_ctl(rd_ctl),
        .wr_pulse(p_pulse), .wr_rs(p_rs), .wr_word(p_word), .oe(db_oe), .dout(db_out)
    );

    hif_ser u_ser (
        .clk(clk), .rst_n(rst_n), .en(ser_en), .dev_id(md.dev_id),
        .cs_n_s(ctl_s[2]), .scl_s(ctl_s[1]), .sdi(sdi),
        .rd_idx(rd_idx), .rd_ctl(rd_ctl),
        .wr_pulse(s_pulse), .wr_rs(s_rs), .wr_word(s_word), .sdo(sdo)
    );

    assign pulse  = ser_en ? s_pulse : p_pulse;
    assign rs_sel = ser_en ? s_rs : p_rs;
    assign idx_wr = pulse & ~rs_sel;
    assign ctl_wr = pulse & rs_sel;
    assign wdata  = ser_en ? s_word : p_word;

    hif_regs #(.NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .ctl_wr(ctl_wr),
        .wdata(wdata), .rd_idx(rd_idx), .rd_ctl(rd_ctl)
    );
endmodule

// File: rtl/hif_front_chk.sv
module hif_front_chk (
    input logic clk,
    input logic rst_n,
    input logic ser_mode,
    input logic cs_n,
    input logic db_oe,
    input logic sdo,
    input logic idx_wr,
    input logic ctl_wr
);
    // R12: a write pulse lasts one cycle
    a_r12_idx_single: assert property (@(posedge clk) disable iff (!rst_n) idx_wr |=> !idx_wr);
    a_r12_ctl_single: assert property (@(posedge clk) disable iff (!rst_n) ctl_wr |=> !ctl_wr);
    a_r12_exclusive:  assert property (@(posedge clk) disable iff (!rst_n) !(idx_wr && ctl_wr));
    // R11: no bus drive in serial mode
    a_r11_no_oe_serial: assert property (@(posedge clk) disable iff (!rst_n) ser_mode |-> !db_oe);
    // R10: serial output quiet in parallel modes
    a_r10_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n) !ser_mode |-> !sdo);
    // R2: deselected long enough means no activity
    a_r2_deselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !(idx_wr || ctl_wr || db_oe));
endmodule

bind hostif_front hif_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ser_mode(mode_strap[2]), .cs_n(cs_n),
    .db_oe(db_oe), .sdo(sdo), .idx_wr(idx_wr), .ctl_wr(ctl_wr)
);

// File: tb/hostif_front_test.sv
`timescale 1ns/1ps
module hostif_front_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_strap = 3'b000;
    logic        cs_n = 1'b1, rs = 1'b0, strobe = 1'b0, dir_rd = 1'b0, sdi = 1'b0;
    logic [15:0] db_in = '0;
    logic [15:0] db_out, wdata;
    logic        db_oe, sdo, idx_wr, ctl_wr;

    int total = 0, bad = 0, oe_err = 0, sdo_err = 0;
    bit oe_ok = 0, sdo_ok = 0;
    logic [16:0] obs[$];
    logic [15:0] mreg [8];
    int midx = 0;

    always #4 clk = ~clk;

    hostif_front uut (
        .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .cs_n(cs_n), .rs(rs),
        .strobe(strobe), .dir_rd(dir_rd), .db_in(db_in), .sdi(sdi),
        .db_out(db_out), .db_oe(db_oe), .sdo(sdo), .idx_wr(idx_wr), .ctl_wr(ctl_wr), .wdata(wdata)
    );

    // per-clock monitor against the expected activity windows
    always @(negedge clk) if (rst_n) begin
        if (idx_wr) obs.push_back({1'b0, wdata});
        if (ctl_wr) obs.push_back({1'b1, wdata});
        if (db_oe && !oe_ok) oe_err++;
        if (sdo && !sdo_ok) sdo_err++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] exp_read(input bit r);
        return r ? mreg[midx] : 16'(midx);
    endfunction

    task automatic expect_wr(input string req, input bit r, input logic [15:0] w);
        idle(6);
        chk({req, " R12 one pulse"}, obs.size(), 1);
        if (obs.size() >= 1) chk({req, " word"}, obs[0], {r, w});
        obs.delete();
        if (!r) midx = int'(w[2:0]);
        else    mreg[midx] = w;
    endtask

    task automatic expect_none(input string req);
        idle(6);
        chk({req, " no pulse"}, obs.size(), 0);
        obs.delete();
    endtask

    task automatic set_mode(input logic [2:0] m);
        cs_n = 1'b1;
        mode_strap = m;
        strobe = (m[2] | m[1]);
        dir_rd = m[1] & ~m[2];
        idle(8);
    endtask

    task automatic one_strobe(input bit is80);
        if (is80) begin strobe = 1'b0; idle(6); strobe = 1'b1; idle(6); end
        else begin dir_rd = 1'b0; strobe = 1'b1; idle(6); strobe = 1'b0; idle(6); end
    endtask

    task automatic par_write(input bit r, input logic [15:0] w);
        bit narrow = mode_strap[0];
        cs_n = 1'b0; rs = r; idle(6);
        if (narrow) begin
            db_in = {w[15:8], 8'hA5}; one_strobe(mode_strap[1]);
            db_in = {w[7:0], 8'h3C};  one_strobe(mode_strap[1]);
        end else begin
            db_in = w; one_strobe(mode_strap[1]);
        end
        cs_n = 1'b1; idle(6);
    endtask

    task automatic par_read(input string req, input bit r);
        bit narrow = mode_strap[0];
        bit is80 = mode_strap[1];
        logic [15:0] got = '0;
        bit seen = 1;
        cs_n = 1'b0; rs = r; idle(6);
        oe_ok = 1;
        for (int b = 0; b < (narrow ? 2 : 1); b++) begin
            if (is80) begin dir_rd = 1'b0; idle(6); end
            else begin dir_rd = 1'b1; idle(2); strobe = 1'b1; idle(6); end
            seen &= db_oe;
            if (narrow) begin
                chk("R6 low lines zero", db_out[7:0], 8'h00);
                if (b == 0) got[15:8] = db_out[15:8];
                else        got[7:0]  = db_out[15:8];
            end else begin
                got = db_out;
            end
            if (is80) begin dir_rd = 1'b1; idle(6); end
            else begin strobe = 1'b0; idle(6); dir_rd = 1'b0; end
        end
        oe_ok = 0;
        cs_n = 1'b1; idle(6);
        chk("R11 oe during read", seen, 1);
        chk(req, got, exp_read(r));
    endtask

    task automatic ser_bit(input bit v);
        strobe = 1'b0; sdi = v; idle(6);
        strobe = 1'b1; idle(6);
    endtask

    task automatic ser_write(input logic [4:0] pat, input bit id, input bit r, input logic [15:0] w);
        logic [7:0] hdr = {pat, id, r, 1'b0};
        cs_n = 1'b0; idle(6);
        for (int i = 7; i >= 0; i--) ser_bit(hdr[i]);
        for (int i = 15; i >= 0; i--) ser_bit(w[i]);
        cs_n = 1'b1; idle(6);
    endtask

    task automatic ser_read(input string req, input bit id, input bit r);
        logic [7:0] hdr = {5'b01110, id, r, 1'b1};
        logic [15:0] got = '0;
        cs_n = 1'b0; idle(6);
        for (int i = 7; i >= 0; i--) ser_bit(hdr[i]);
        sdo_ok = 1;
        for (int i = 15; i >= 0; i--) begin
            strobe = 1'b0; idle(6);
            got[i] = sdo;
            strobe = 1'b1; idle(6);
        end
        cs_n = 1'b1; idle(6);
        sdo_ok = 0;
        chk(req, got, exp_read(r));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) mreg[i] = '0;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R13 reset state
        chk("R13 db_oe", db_oe, 0);
        chk("R13 sdo", sdo, 0);
        chk("R13 pulses", {idx_wr, ctl_wr}, 0);
        set_mode(3'b010);
        par_read("R13 control zero", 1);

        // R1 parallel modes, R3/R4/R5/R6 function
        for (int m = 0; m < 4; m++) begin
            string tag = (m >= 2) ? "R5" : "R4";
            set_mode(3'(m));
            par_write(0, 16'(m + 2));
            expect_wr({"R1 R3 ", tag, " index"}, 0, 16'(m + 2));
            par_write(1, 16'hC35A ^ (16'h1111 * 16'(m)));
            expect_wr({"R3 ", tag, " control"}, 1, 16'hC35A ^ (16'h1111 * 16'(m)));
            par_read({"R3 R6 ", tag, " control read"}, 1);
            par_read({"R3 ", tag, " status read"}, 0);
        end

        // R2 deselected strobe ignored
        set_mode(3'b010);
        rs = 1'b1; db_in = 16'hDEAD;
        one_strobe(1);
        expect_none("R2");
        par_read("R2 unchanged", 1);

        // R7 lone byte discarded
        set_mode(3'b011);
        cs_n = 1'b0; rs = 1'b1; idle(6);
        db_in = 16'h7700; one_strobe(1);
        cs_n = 1'b1; idle(6);
        expect_none("R7 lone byte");
        par_write(1, 16'h1234);
        expect_wr("R7 fresh pair", 1, 16'h1234);
        set_mode(3'b001);
        par_read("R7 R6 68 narrow read", 1);

        // R8 serial writes, R10 reads
        set_mode(3'b101);
        ser_write(5'b01110, 1, 0, 16'h0005);
        expect_wr("R8 index", 0, 16'h0005);
        ser_write(5'b01110, 1, 1, 16'h3C96);
        expect_wr("R8 control", 1, 16'h3C96);
        ser_read("R10 control", 1, 1);
        ser_read("R10 status", 1, 0);

        // R9 rejected start bytes
        ser_write(5'b01110, 0, 1, 16'hFFFF);
        expect_none("R9 wrong id");
        ser_write(5'b01111, 1, 1, 16'hFFFF);
        expect_none("R9 wrong pattern");
        ser_read("R9 unchanged", 1, 1);

        // R1 ID comes from strap bit 0
        set_mode(3'b100);
        ser_write(5'b01110, 0, 1, 16'h0F0F);
        expect_wr("R1 id zero", 1, 16'h0F0F);
        ser_write(5'b01110, 1, 1, 16'hAAAA);
        expect_none("R1 id one rejected");

        chk("R11 oe outside reads", oe_err, 0);
        chk("R10 sdo outside reads", sdo_err, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule